// File: doc/BRIEF.md
# Pixel Output Formatter with Blanking

This block is the last digital stage behind a pixel converter. It takes each converted code, decides whether to keep it or replace it with a blanking word, carries it through a fixed pipeline paced by the data clock, and presents it on the output bus. It can present the word as straight binary or as Gray code. It can hold the word in an output register or pass it straight through. It can also release the bus by dropping an output enable.

All logic runs on one system clock `clk`. The sample clock and the data clock arrive as plain levels and are sampled on `clk`. Each has its own polarity bit. The block acts on an active edge, which is a transition of the input into its active level. The data path carries no valid/ready handshake and accepts no back-pressure. A word is taken at each sample-clock active edge and moves one stage at each data-clock active edge. The producer and the consumer must both keep pace with the data clock. The blanking and clamp strobes are levels. They are read at the sample-clock edge, so a substitution stays with the pixel it replaced through the whole latency.

Top module: `pixout_fmt`

## Requirements
- R1: With the latch-mode bit at 0, the word captured at a sample edge appears on `data_o` right after the ninth data-clock active edge that follows the capture.
- R2: `pix_i` is captured only on a sample-clock active edge. The active level equals `smp_pol_i`. Between edges the captured word is held, and each data-clock edge with no new sample pushes the same word again.
- R3: When the blank strobe is active at the capture edge and the clamp strobe is not, and `blk_black_i` is 0, the captured word is all zeros.
- R4: In the case of R3 with `blk_black_i` at 1, the captured word is `clamp_lvl_i`, zero-extended into the low bits.
- R5: When the clamp strobe is active at the capture edge, `pix_i` is captured unchanged, whatever the blank strobe is.
- R6: The blank strobe is active when it equals `blk_pol_i`, and the clamp strobe is active when it equals `clp_pol_i`. A bit value of 0 means active low and 1 means active high.
- R7: The pipeline and the output register change only on a data-clock active edge. The active level equals `dck_pol_i`. With no such edge, a latched `data_o` keeps its value.
- R8: With `gray_i` at 0 the output is the word in straight binary. With `gray_i` at 1 the output is the word XOR the word shifted right by one bit.
- R9: With `transp_i` at 1, `data_o` bypasses the output register. It shows the word after the eighth data-clock edge following capture, and it follows `gray_i` in the same cycle.
- R10: `data_oe_o` is the inverse of `float_i`. `float_i` has no effect on the value of `data_o`.
- R11: After reset, every pipeline stage, the capture register and the output register hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_clk_i | input | 1 | Sample clock level |
| dat_clk_i | input | 1 | Data clock level |
| pix_i | input | DW | Converted pixel code |
| blank_i | input | 1 | Blanking strobe |
| clamp_i | input | 1 | Clamp strobe |
| smp_pol_i | input | 1 | Sample clock active level |
| dck_pol_i | input | 1 | Data clock active level |
| blk_pol_i | input | 1 | Blank strobe active level |
| clp_pol_i | input | 1 | Clamp strobe active level |
| blk_black_i | input | 1 | Blank to black level (1) or to zero (0) |
| gray_i | input | 1 | Gray output coding when 1 |
| transp_i | input | 1 | Transparent output path when 1 |
| float_i | input | 1 | Release the bus when 1 |
| clamp_lvl_i | input | CLW | Black clamp level |
| data_o | output | DW | Output data word |
| data_oe_o | output | 1 | Output enable, high drives the bus |

## Verification
The hardest case to reach from the ports is a change of strobe polarity in the middle of a stream. If the level and the polarity bit change in different cycles, the edge detectors see a false edge, and a word that should not exist enters the pipeline. The stimulus changes each polarity bit in the same cycle as the level it governs, so the input stays inactive. It then checks that the tick count of the expected model and the position of the output stay in step. Periods with a missing sample edge or a missing data-clock edge are mixed into the random stream. This shows that the word is repeated or held rather than shifted.

// File: rtl/pixout_pkg.sv
package pixout_pkg;

  typedef enum logic {
    CODE_BIN  = 1'b0,
    CODE_GRAY = 1'b1
  } code_e;

  typedef enum logic {
    OUT_LATCHED = 1'b0,
    OUT_BYPASS  = 1'b1
  } path_e;

  // A strobe is active when its level equals its polarity bit.
  function automatic logic is_active(input logic lvl, input logic pol);
    return lvl == pol;
  endfunction

endpackage

// File: rtl/pixout_edge.sv
module pixout_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic pol_i,
  output logic tick_o
);
  import pixout_pkg::*;

  logic act;
  logic act_q;

  assign act = is_active(lvl_i, pol_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign tick_o = act & ~act_q;
endmodule

// File: rtl/pixout_capture.sv
module pixout_capture #(
  parameter int DW  = 12,
  parameter int CLW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_tick_i,
  input  logic [DW-1:0] pix_i,
  input  logic          blank_i,
  input  logic          clamp_i,
  input  logic          blk_pol_i,
  input  logic          clp_pol_i,
  input  logic          blk_black_i,
  input  logic [CLW-1:0] clamp_lvl_i,
  output logic [DW-1:0] hold_o
);
  import pixout_pkg::*;

  logic          blk_act;
  logic          clp_act;
  logic          subst;
  logic [DW-1:0] lvl_ext;
  logic [DW-1:0] fill;
  logic [DW-1:0] hold_q;

  assign blk_act = is_active(blank_i, blk_pol_i);
  assign clp_act = is_active(clamp_i, clp_pol_i);
  assign subst   = blk_act & ~clp_act;   // clamp overrides blanking (R5)

  generate
    if (DW > CLW) begin : g_widen
      assign lvl_ext = {{(DW-CLW){1'b0}}, clamp_lvl_i};
    end else begin : g_narrow
      assign lvl_ext = clamp_lvl_i[DW-1:0];
    end
  endgenerate

  assign fill = blk_black_i ? lvl_ext : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= '0;
    else if (smp_tick_i) hold_q <= subst ? fill : pix_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/pixout_delay.sv
module pixout_delay #(
  parameter int DW   = 12,
  parameter int NSTG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] head_o,
  output logic [DW-1:0] tail_o
);
  genvar i;
  generate
    for (i = 0; i < NSTG; i++) begin : g_stg
      logic [DW-1:0] q;
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     q <= '0;
          else if (adv_i) q <= din_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     q <= '0;
          else if (adv_i) q <= g_stg[i-1].q;
        end
      end
    end
  endgenerate

  assign head_o = g_stg[0].q;
  assign tail_o = g_stg[NSTG-1].q;
endmodule

// File: rtl/pixout_drive.sv
module pixout_drive #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [DW-1:0] word_i,
  input  logic          gray_i,
  input  logic          transp_i,
  input  logic          float_i,
  output logic [DW-1:0] out_q_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  import pixout_pkg::*;

  logic [DW-1:0] gray_w;
  logic [DW-1:0] coded;
  logic [DW-1:0] out_q;

  genvar b;
  generate
    for (b = 0; b < DW; b++) begin : g_bit
      if (b == DW-1) begin : g_msb
        assign gray_w[b] = word_i[b];
      end else begin : g_low
        assign gray_w[b] = word_i[b] ^ word_i[b+1];
      end
    end
  endgenerate

  assign coded = (gray_i == CODE_GRAY) ? gray_w : word_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= '0;
    else if (adv_i) out_q <= coded;
  end

  assign out_q_o   = out_q;
  assign data_o    = (transp_i == OUT_BYPASS) ? coded : out_q;
  assign data_oe_o = ~float_i;
endmodule

// File: rtl/pixout_fmt.sv
module pixout_fmt #(
  parameter int DW  = 12,
  parameter int CLW = 8,
  parameter int LAT = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_clk_i,
  input  logic           dat_clk_i,
  input  logic [DW-1:0]  pix_i,
  input  logic           blank_i,
  input  logic           clamp_i,
  input  logic           smp_pol_i,
  input  logic           dck_pol_i,
  input  logic           blk_pol_i,
  input  logic           clp_pol_i,
  input  logic           blk_black_i,
  input  logic           gray_i,
  input  logic           transp_i,
  input  logic           float_i,
  input  logic [CLW-1:0] clamp_lvl_i,
  output logic [DW-1:0]  data_o,
  output logic           data_oe_o
);
  // Stages ahead of the output register; the register supplies the last one.
  localparam int NSTG = LAT - 1;

  logic          smp_tick;
  logic          dat_tick;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] stage0;
  logic [DW-1:0] tail;
  logic [DW-1:0] out_q;

  pixout_edge u_smp_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (smp_clk_i),
    .pol_i  (smp_pol_i),
    .tick_o (smp_tick)
  );

  pixout_edge u_dck_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (dat_clk_i),
    .pol_i  (dck_pol_i),
    .tick_o (dat_tick)
  );

  pixout_capture #(.DW(DW), .CLW(CLW)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_tick_i  (smp_tick),
    .pix_i       (pix_i),
    .blank_i     (blank_i),
    .clamp_i     (clamp_i),
    .blk_pol_i   (blk_pol_i),
    .clp_pol_i   (clp_pol_i),
    .blk_black_i (blk_black_i),
    .clamp_lvl_i (clamp_lvl_i),
    .hold_o      (hold_q)
  );

  pixout_delay #(.DW(DW), .NSTG(NSTG)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (dat_tick),
    .din_i  (hold_q),
    .head_o (stage0),
    .tail_o (tail)
  );

  pixout_drive #(.DW(DW)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (dat_tick),
    .word_i    (tail),
    .gray_i    (gray_i),
    .transp_i  (transp_i),
    .float_i   (float_i),
    .out_q_o   (out_q),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );
endmodule

// File: rtl/pixout_fmt_chk.sv
module pixout_fmt_chk #(
  parameter int DW  = 12,
  parameter int CLW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           smp_tick,
  input logic           dat_tick,
  input logic [DW-1:0]  pix_i,
  input logic           blank_i,
  input logic           clamp_i,
  input logic           blk_pol_i,
  input logic           clp_pol_i,
  input logic           blk_black_i,
  input logic [CLW-1:0] clamp_lvl_i,
  input logic [DW-1:0]  hold_q,
  input logic [DW-1:0]  stage0,
  input logic [DW-1:0]  out_q
);
  logic blk_on;
  logic clp_on;
  assign blk_on = (blank_i == blk_pol_i);
  assign clp_on = (clamp_i == clp_pol_i);

  AST_HOLD_ONLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_tick |=> $stable(hold_q)); // R2

  AST_BLANK_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_tick && blk_on && !clp_on && !blk_black_i) |=> (hold_q == '0)); // R3

  AST_BLANK_TO_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_tick && blk_on && !clp_on && blk_black_i) |=> (hold_q == DW'($past(clamp_lvl_i)))); // R4

  AST_CLAMP_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_tick && clp_on) |=> (hold_q == $past(pix_i))); // R5

  AST_FIRST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dat_tick |=> (stage0 == $past(hold_q))); // R1

  AST_OUT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_tick |=> $stable(out_q)); // R7
endmodule

bind pixout_fmt pixout_fmt_chk #(.DW(DW), .CLW(CLW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_tick    (smp_tick),
  .dat_tick    (dat_tick),
  .pix_i       (pix_i),
  .blank_i     (blank_i),
  .clamp_i     (clamp_i),
  .blk_pol_i   (blk_pol_i),
  .clp_pol_i   (clp_pol_i),
  .blk_black_i (blk_black_i),
  .clamp_lvl_i (clamp_lvl_i),
  .hold_q      (hold_q),
  .stage0      (stage0),
  .out_q       (out_q)
);

// File: tb/pixout_fmt_tb.sv
module pixout_fmt_tb;
  localparam int DW  = 12;
  localparam int CLW = 8;
  localparam int LAT = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_clk_i = 1'b0, dat_clk_i = 1'b0;
  logic [DW-1:0] pix_i = '0;
  logic blank_i = 1'b0, clamp_i = 1'b0;
  logic smp_pol_i = 1'b1, dck_pol_i = 1'b1, blk_pol_i = 1'b1, clp_pol_i = 1'b1;
  logic blk_black_i = 1'b0, gray_i = 1'b0, transp_i = 1'b0, float_i = 1'b0;
  logic [CLW-1:0] clamp_lvl_i = 8'd128;
  logic [DW-1:0] data_o;
  logic data_oe_o;

  int checks = 0;
  int errors = 0;
  int ticks = 0;
  bit done = 1'b0;
  logic [DW-1:0] hist [0:4095];
  logic [DW-1:0] hold_raw = '0;

  always #5 clk = ~clk;

  pixout_fmt #(.DW(DW), .CLW(CLW), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_clk_i(smp_clk_i), .dat_clk_i(dat_clk_i),
    .pix_i(pix_i), .blank_i(blank_i), .clamp_i(clamp_i),
    .smp_pol_i(smp_pol_i), .dck_pol_i(dck_pol_i), .blk_pol_i(blk_pol_i),
    .clp_pol_i(clp_pol_i), .blk_black_i(blk_black_i), .gray_i(gray_i),
    .transp_i(transp_i), .float_i(float_i), .clamp_lvl_i(clamp_lvl_i),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  function automatic logic [DW-1:0] enc(input logic [DW-1:0] v, input logic g);
    return g ? (v ^ (v >> 1)) : v;
  endfunction

  function automatic logic [DW-1:0] hget(input int i);
    return (i < 0) ? '0 : hist[i];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One pixel period: sample edge, then data-clock edge, then check.
  task automatic period(input logic [DW-1:0] pix, input bit bact, input bit cact,
                        input bit do_s, input bit do_d, input string tag);
    logic [DW-1:0] exp;
    @(negedge clk);
    pix_i   = pix;
    blank_i = bact ? blk_pol_i : ~blk_pol_i;
    clamp_i = cact ? clp_pol_i : ~clp_pol_i;
    if (do_s) begin
      smp_clk_i = smp_pol_i;
      hold_raw = (bact && !cact) ? (blk_black_i ? DW'(clamp_lvl_i) : '0) : pix;
    end
    @(negedge clk);
    smp_clk_i = ~smp_pol_i;
    @(negedge clk);
    if (do_d) dat_clk_i = dck_pol_i;
    @(negedge clk);
    dat_clk_i = ~dck_pol_i;
    if (do_d) begin
      hist[ticks] = hold_raw;
      ticks++;
    end
    exp = transp_i ? enc(hget(ticks - (LAT - 1)), gray_i) : enc(hget(ticks - LAT), gray_i);
    chk(tag, data_o, exp);
    chk("R10", {{(DW-1){1'b0}}, data_oe_o}, {{(DW-1){1'b0}}, ~float_i});
  endtask

  // Polarity change with every level held inactive under its new polarity (R6).
  task automatic set_pol(input logic s, input logic d, input logic b, input logic c);
    @(negedge clk);
    smp_pol_i = s; smp_clk_i = ~s;
    dck_pol_i = d; dat_clk_i = ~d;
    blk_pol_i = b; blank_i = ~b;
    clp_pol_i = c; clamp_i = ~c;
  endtask

  task automatic rand_run(input int n, input string tag, input int skip_s, input int skip_d);
    for (int k = 0; k < n; k++) begin
      logic [DW-1:0] p;
      bit ba, ca, ds, dd;
      p  = DW'($urandom);
      ba = ($urandom % 4) == 0;
      ca = ($urandom % 4) == 0;
      ds = ($urandom % 100) >= skip_s;
      dd = ($urandom % 100) >= skip_d;
      blk_black_i = $urandom % 2;
      period(p, ba, ca, ds, dd, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4021);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", data_o, '0);

    // R1, R11: random stream, binary, latched; first outputs come from reset zeros
    rand_run(120, "R1", 0, 0);

    // R3: blanking to zero, clamp inactive
    blk_black_i = 1'b0;
    for (int k = 0; k < 12; k++) period(DW'($urandom), 1'b1, 1'b0, 1'b1, 1'b1, "R3");

    // R4: blanking to black level, maximum level and zero level
    blk_black_i = 1'b1;
    clamp_lvl_i = 8'hFF;
    for (int k = 0; k < 11; k++) period(12'hFFF, 1'b1, 1'b0, 1'b1, 1'b1, "R4");
    clamp_lvl_i = 8'h00;
    for (int k = 0; k < 10; k++) period(12'h5A5, 1'b1, 1'b0, 1'b1, 1'b1, "R4");
    clamp_lvl_i = 8'h80;

    // R5: clamp and blank together keep the pixel
    for (int k = 0; k < 12; k++) period(DW'($urandom), 1'b1, 1'b1, 1'b1, 1'b1, "R5");

    // R6: all strobes active low
    set_pol(1'b0, 1'b0, 1'b0, 1'b0);
    rand_run(120, "R6", 0, 0);

    // R2: sample edges missing in some periods
    rand_run(120, "R2", 25, 0);

    // R7: data-clock edges missing in some periods
    rand_run(120, "R7", 0, 25);
    set_pol(1'b1, 1'b0, 1'b1, 1'b0);
    rand_run(60, "R7", 10, 10);

    // R8: Gray coding, including an all-ones word
    gray_i = 1'b1;
    for (int k = 0; k < 10; k++) period(12'hFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    rand_run(120, "R8", 0, 0);

    // R9: transparent path in both codings
    transp_i = 1'b1;
    rand_run(80, "R9", 0, 0);
    gray_i = 1'b0;
    rand_run(80, "R9", 10, 10);
    transp_i = 1'b0;

    // R10: bus released, word unaffected
    float_i = 1'b1;
    rand_run(60, "R10", 0, 0);
    float_i = 1'b0;
    rand_run(20, "R1", 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule